// File: doc/BRIEF.md
# Floating-Point Operand Unpacker and Classifier

This block takes a memory operand of up to three 32-bit words and turns it into one unpacked internal number: a sign, a signed unbiased exponent, a 96-bit mantissa whose leading one sits at the top bit, and a class code. It accepts signed byte, halfword and 32-bit integers as well as single, double and 96-bit extended floating-point values. Integers and denormals are normalized with a leading-zero count and a barrel shift. NaNs leave the block quiet, and signalling NaNs are tagged by class and by a flag.

The datapath is combinational. A parameter adds one output register stage, which is on by default. A downstream arithmetic unit reads the outputs and never has to look at the packed format again.

Top module: `fp_operand_unpacker`

## Requirements
- R1: For every supported format, including integers, `outSign` equals bit 31 of `opWord0`.
- R2: Format codes are 0 byte, 1 halfword, 2 long, 3 single, 4 double and 5 extended. Codes 6 and 7 set `fmtErr` and drive every other output to zero.
- R3: A float with a zero exponent field and a zero fraction, or an integer of value zero, gives class ZERO (0) with zero exponent and zero mantissa.
- R4: A single value (exponent in `opWord0[30:23]`, bias 127, fraction in `opWord0[22:0]`) or a double value (exponent in `opWord0[30:20]`, bias 1023, fraction in `opWord0[19:0]` then `opWord1`) with a field that is neither zero nor all ones gives class NUM (1). Its exponent is the field minus the bias. Its mantissa has bit 95 set and the fraction directly below.
- R5: A single or double value with a zero exponent field and a non-zero fraction starts at exponent 1 minus the bias with no implied one. It is then shifted left until bit 95 is set, and each shift position is subtracted from the exponent.
- R6: An all-ones exponent field with a zero fraction gives class INF (2) with zero exponent and zero mantissa.
- R7: An all-ones exponent field with a non-zero fraction gives a NaN. Its mantissa is the fraction copied unchanged and its exponent is zero. If mantissa bit 94 is set, the class is QNAN (3) and `snanFlag` stays low.
- R8: If such a NaN has mantissa bit 94 clear, the block sets that bit, reports class SNAN (4) and raises `snanFlag`.
- R9: The extended format takes its exponent from `opWord0[30:16]` with bias 16383. Its mantissa is `opWord1`, then `opWord2`, then 32 zero bits, and the explicit integer bit counts as part of the fraction. A normal value ORs a one into bit 95. A zero field with a non-zero fraction starts at exponent minus 16383 and is normalized. Infinity requires `opWord1` and `opWord2` to be all zero.
- R10: A byte operand is taken from `opWord0[31:24]`, a halfword from `opWord0[31:16]` and a long from all of `opWord0`, each read as two's complement. The magnitude of a non-zero value is normalized to bit 95, with exponent equal to the index of its highest set bit.
- R11: Every output of class NUM has mantissa bit 95 set.
- R12: With the output register enabled, outputs change only at the clock edge after the inputs, and reset clears them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opWord0 | input | 32 | First operand word (sign, exponent, high fraction or integer) |
| opWord1 | input | 32 | Second operand word |
| opWord2 | input | 32 | Third operand word (extended only) |
| fmtSel | input | 3 | Operand format code |
| outSign | output | 1 | Sign of the unpacked number |
| outExp | output | 17 | Unbiased exponent, two's complement |
| outMant | output | 96 | Mantissa, leading one at bit 95 |
| outClass | output | 3 | Class code: ZERO, NUM, INF, QNAN, SNAN |
| snanFlag | output | 1 | A signalling NaN was quieted |
| fmtErr | output | 1 | Unsupported format code |

## Verification
The assertions assume that the inputs hold two-state values and are stable across each rising edge. Under that assumption every class/mantissa relation on the registered outputs must hold for any operand bits and any of the eight format codes. The stimulus changes inputs only on falling edges and never drives X. It mixes directed corner operands with pseudo-random words over all eight format codes, so the invalid codes and the odd extended encodings are reached as well as the ordinary values.

// File: rtl/fp_unpack_pkg.sv
package fp_unpack_pkg;
  localparam int WORD_W = 32;
  localparam int MANT_W = 96;
  localparam int EXP_W  = 17;
  localparam int LZ_W   = $clog2(MANT_W + 1);
  localparam int FLD_W  = 15;

  typedef enum logic [2:0] {
    FMT_BYTE   = 3'd0,
    FMT_HALF   = 3'd1,
    FMT_LONG   = 3'd2,
    FMT_SINGLE = 3'd3,
    FMT_DOUBLE = 3'd4,
    FMT_EXT    = 3'd5
  } opFormat_e;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } numClass_e;

  // strobes from the format decoder to the datapath
  typedef struct packed {
    logic isInt;
    logic isByte;
    logic isHalf;
    logic isSingle;
    logic isDouble;
    logic isExt;
    logic badFmt;
  } unpackCtl_t;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
    numClass_e         cls;
    logic              snan;
    logic              err;
  } unpackRes_t;
endpackage

// File: rtl/fp_unpack_ctrl.sv
module fp_unpack_ctrl
  import fp_unpack_pkg::*;
(
  input  logic [2:0]  fmtSel,
  output unpackCtl_t  ctl
);
  always_comb begin
    ctl = '0;
    case (fmtSel)
      FMT_BYTE:   begin ctl.isInt = 1'b1; ctl.isByte = 1'b1; end
      FMT_HALF:   begin ctl.isInt = 1'b1; ctl.isHalf = 1'b1; end
      FMT_LONG:   ctl.isInt    = 1'b1;
      FMT_SINGLE: ctl.isSingle = 1'b1;
      FMT_DOUBLE: ctl.isDouble = 1'b1;
      FMT_EXT:    ctl.isExt    = 1'b1;
      default:    ctl.badFmt   = 1'b1;
    endcase
  end
endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W  = 96,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count
);
  // highest set bit wins because later iterations overwrite
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_shl.sv
module fp_shl #(
  parameter int W  = 96,
  parameter int SW = 7
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:SW];
  assign stage[0] = din;
  for (genvar g = 0; g < SW; g++) begin : g_stage
    assign stage[g+1] = amt[g] ? (stage[g] << (2 ** g)) : stage[g];
  end
  assign dout = stage[SW];
endmodule

// File: rtl/fp_unpack_dp.sv
module fp_unpack_dp
  import fp_unpack_pkg::*;
(
  input  unpackCtl_t         ctl,
  input  logic [WORD_W-1:0]  w0,
  input  logic [WORD_W-1:0]  w1,
  input  logic [WORD_W-1:0]  w2,
  output unpackRes_t         res
);
  localparam int INT_PAD = MANT_W - WORD_W;

  // field extraction
  logic [FLD_W-1:0]  expField;
  logic [FLD_W-1:0]  expOnes;
  logic [EXP_W-1:0]  bias;
  logic [MANT_W-1:0] fracMant;

  always_comb begin
    expField = '0;
    expOnes  = '1;
    bias     = '0;
    fracMant = '0;
    if (ctl.isSingle) begin
      expField = FLD_W'(w0[30:23]);
      expOnes  = FLD_W'(8'hFF);
      bias     = EXP_W'(127);
      fracMant = {1'b0, w0[22:0], 72'b0};
    end else if (ctl.isDouble) begin
      expField = FLD_W'(w0[30:20]);
      expOnes  = FLD_W'(11'h7FF);
      bias     = EXP_W'(1023);
      fracMant = {1'b0, w0[19:0], w1, 43'b0};
    end else if (ctl.isExt) begin
      expField = w0[30:16];
      expOnes  = '1;
      bias     = EXP_W'(16383);
      fracMant = {w1, w2, 32'b0};
    end
  end

  // integer magnitude
  logic [WORD_W-1:0] intVal;
  logic [WORD_W-1:0] intMag;

  always_comb begin
    if (ctl.isByte)      intVal = {{24{w0[31]}}, w0[31:24]};
    else if (ctl.isHalf) intVal = {{16{w0[31]}}, w0[31:16]};
    else                 intVal = w0;
    intMag = intVal[WORD_W-1] ? (~intVal + 1'b1) : intVal;
  end

  // classification before normalization
  logic [MANT_W-1:0] preMant;
  logic [EXP_W-1:0]  preExp;
  numClass_e         preCls;

  always_comb begin
    preMant = '0;
    preExp  = '0;
    preCls  = CLS_ZERO;
    if (ctl.isInt) begin
      if (intMag != '0) begin
        preMant = {intMag, {INT_PAD{1'b0}}};
        preExp  = EXP_W'(WORD_W - 1);
        preCls  = CLS_NUM;
      end
    end else if (!ctl.badFmt) begin
      if (expField == '0) begin
        if (fracMant != '0) begin
          preMant = fracMant;
          preExp  = ctl.isExt ? (EXP_W'(0) - bias) : (EXP_W'(1) - bias);
          preCls  = CLS_NUM;
        end
      end else if (expField == expOnes) begin
        if (fracMant == '0) begin
          preCls = CLS_INF;
        end else begin
          preMant = fracMant;
          preCls  = CLS_QNAN;
        end
      end else begin
        preMant = fracMant | {1'b1, {(MANT_W-1){1'b0}}};
        preExp  = EXP_W'(expField) - bias;
        preCls  = CLS_NUM;
      end
    end
  end

  // normalization
  logic [LZ_W-1:0]   lzCount;
  logic [MANT_W-1:0] normMant;

  fp_lzc #(.W(MANT_W), .CW(LZ_W)) lzc_i (
    .din   (preMant),
    .count (lzCount)
  );

  fp_shl #(.W(MANT_W), .SW(LZ_W)) shl_i (
    .din  (preMant),
    .amt  (lzCount),
    .dout (normMant)
  );

  // final assembly with NaN quieting
  always_comb begin
    res      = '0;
    res.err  = ctl.badFmt;
    res.sign = ctl.badFmt ? 1'b0 : w0[31];
    res.cls  = preCls;
    res.mant = preMant;
    res.exp  = preExp;
    if (preCls == CLS_NUM) begin
      res.mant = normMant;
      res.exp  = preExp - EXP_W'(lzCount);
    end else if (preCls == CLS_QNAN && !preMant[MANT_W-2]) begin
      res.mant[MANT_W-2] = 1'b1;
      res.cls            = CLS_SNAN;
      res.snan           = 1'b1;
    end
  end
endmodule

// File: rtl/fp_operand_unpacker.sv
module fp_operand_unpacker
  import fp_unpack_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       opWord0,
  input  logic [31:0]       opWord1,
  input  logic [31:0]       opWord2,
  input  logic [2:0]        fmtSel,
  output logic              outSign,
  output logic [16:0]       outExp,
  output logic [95:0]       outMant,
  output logic [2:0]        outClass,
  output logic              snanFlag,
  output logic              fmtErr
);
  unpackCtl_t ctl;
  unpackRes_t resD;
  unpackRes_t resQ;

  fp_unpack_ctrl ctrl_i (
    .fmtSel (fmtSel),
    .ctl    (ctl)
  );

  fp_unpack_dp dp_i (
    .ctl (ctl),
    .w0  (opWord0),
    .w1  (opWord1),
    .w2  (opWord2),
    .res (resD)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resQ <= '0;
      else       resQ <= resD;
    end
  end else begin : g_comb
    assign resQ = resD;
  end

  assign outSign  = resQ.sign;
  assign outExp   = resQ.exp;
  assign outMant  = resQ.mant;
  assign outClass = resQ.cls;
  assign snanFlag = resQ.snan;
  assign fmtErr   = resQ.err;

  AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outClass <= 3'd4);                                                  // R7
  AST_NUM_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (outClass == 3'd1) |-> outMant[95]);                                // R11
  AST_NAN_QUIETED: assert property (@(posedge clk) disable iff (!rstN)
    (outClass == 3'd3 || outClass == 3'd4) |-> outMant[94]);            // R8
  AST_SNAN_TAGGED: assert property (@(posedge clk) disable iff (!rstN)
    snanFlag |-> (outClass == 3'd4));                                   // R8
  AST_INF_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (outClass == 3'd2) |-> (outMant == '0 && outExp == '0));            // R6
  AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (outClass == 3'd0) |-> (outMant == '0 && outExp == '0));            // R3
  AST_BADFMT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    fmtErr |-> (!outSign && outMant == '0 && outClass == 3'd0 && !snanFlag)); // R2
endmodule

// File: tb/fp_operand_unpacker_tb.sv
module fp_operand_unpacker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opWord0 = '0, opWord1 = '0, opWord2 = '0;
  logic [2:0]  fmtSel = '0;
  logic        outSign, snanFlag, fmtErr;
  logic [16:0] outExp;
  logic [95:0] outMant;
  logic [2:0]  outClass;

  int checks = 0;
  int failures = 0;
  logic [118:0] prevExp = '0;
  logic [31:0]  rngState = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  fp_operand_unpacker dut_i (
    .clk(clk), .rstN(rstN), .opWord0(opWord0), .opWord1(opWord1),
    .opWord2(opWord2), .fmtSel(fmtSel), .outSign(outSign), .outExp(outExp),
    .outMant(outMant), .outClass(outClass), .snanFlag(snanFlag), .fmtErr(fmtErr)
  );

  // behavioural model: {sign, exp17, mant96, class3, snan, err}
  function automatic logic [118:0] refModel(input logic [31:0] a, b, c,
                                            input logic [2:0] f);
    logic s, sn, bad;
    int e, ew, bias, ones;
    logic [95:0] m, fr;
    logic [2:0] cl;
    longint v, mag;
    s = a[31]; e = 0; m = '0; cl = 3'd0; sn = 1'b0; bad = 1'b0;
    if (f > 3'd5) begin
      return {1'b0, 17'd0, 96'd0, 3'd0, 1'b0, 1'b1};
    end
    if (f <= 3'd2) begin
      if (f == 3'd0)      v = longint'($signed(a[31:24]));
      else if (f == 3'd1) v = longint'($signed(a[31:16]));
      else                v = longint'($signed(a));
      mag = (v < 0) ? -v : v;
      if (mag != 0) begin
        m = {mag[31:0], 64'd0}; e = 31; cl = 3'd1;
        while (!m[95]) begin m = m << 1; e = e - 1; end
      end
    end else begin
      if (f == 3'd3) begin
        ew = int'(a[30:23]); bias = 127; ones = 255; fr = {1'b0, a[22:0], 72'd0};
      end else if (f == 3'd4) begin
        ew = int'(a[30:20]); bias = 1023; ones = 2047; fr = {1'b0, a[19:0], b, 43'd0};
      end else begin
        ew = int'(a[30:16]); bias = 16383; ones = 32767; fr = {b, c, 32'd0};
      end
      if (ew == 0) begin
        if (fr != 0) begin
          m = fr; cl = 3'd1;
          e = (f == 3'd5) ? -bias : 1 - bias;
          while (!m[95]) begin m = m << 1; e = e - 1; end
        end
      end else if (ew == ones) begin
        if (fr == 0) cl = 3'd2;
        else begin
          m = fr;
          if (m[94]) cl = 3'd3;
          else begin m[94] = 1'b1; cl = 3'd4; sn = 1'b1; end
        end
      end else begin
        m = fr; m[95] = 1'b1; e = ew - bias; cl = 3'd1;
      end
    end
    return {s, e[16:0], m, cl, sn, bad};
  endfunction

  task automatic check(input string tag, input logic [118:0] exp);
    logic [118:0] got;
    got = {outSign, outExp, outMant, outClass, snanFlag, fmtErr};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, confirm the output holds before the rising edge,
  // then compare at the next falling edge
  task automatic runVec(input string tag, input logic [31:0] a, b, c,
                        input logic [2:0] f);
    logic [118:0] e;
    @(negedge clk);
    opWord0 = a; opWord1 = b; opWord2 = c; fmtSel = f;
    e = refModel(a, b, c, f);
    #1 check("R12 hold", prevExp);
    @(negedge clk);
    check(tag, e);
    prevExp = e;
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, r2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 reset", '0);
    rstN = 1'b1;
    // single precision
    runVec("R4 single one",      32'h3F80_0000, 0, 0, 3'd3);
    runVec("R1 R4 single neg",   32'hC020_0000, 0, 0, 3'd3);
    runVec("R5 single min denorm", 32'h0000_0001, 0, 0, 3'd3);
    runVec("R5 single denorm",   32'h8040_0000, 0, 0, 3'd3);
    runVec("R3 single neg zero", 32'h8000_0000, 0, 0, 3'd3);
    runVec("R6 single inf",      32'h7F80_0000, 0, 0, 3'd3);
    runVec("R7 single qnan",     32'h7FC0_0001, 0, 0, 3'd3);
    runVec("R8 single snan",     32'hFF80_0001, 0, 0, 3'd3);
    // double precision
    runVec("R4 double one",      32'h3FF0_0000, 32'h0000_0000, 0, 3'd4);
    runVec("R4 double frac",     32'h4009_21FB, 32'h5444_2D18, 0, 3'd4);
    runVec("R5 double denorm",   32'h0000_0000, 32'h0000_0001, 0, 3'd4);
    runVec("R8 double snan",     32'h7FF0_0000, 32'h0000_0005, 0, 3'd4);
    runVec("R6 double inf",      32'hFFF0_0000, 32'h0000_0000, 0, 3'd4);
    runVec("R3 double zero",     32'h0000_0000, 32'h0000_0000, 0, 3'd4);
    // extended
    runVec("R9 ext one",         32'h3FFF_0000, 32'h8000_0000, 0, 3'd5);
    runVec("R9 ext unnormal",    32'h4000_0000, 32'h0000_0001, 32'h2, 3'd5);
    runVec("R9 ext denorm",      32'h0000_0000, 32'h0000_0000, 32'h10, 3'd5);
    runVec("R9 ext zero exp int bit", 32'h8000_0000, 32'h8000_0000, 0, 3'd5);
    runVec("R9 ext inf",         32'h7FFF_0000, 0, 0, 3'd5);
    runVec("R9 R8 ext int bit only", 32'h7FFF_1234, 32'h8000_0000, 0, 3'd5);
    runVec("R9 R7 ext qnan",     32'hFFFF_0000, 32'hC000_0000, 32'h1, 3'd5);
    runVec("R3 ext zero",        32'h0000_FFFF, 0, 0, 3'd5);
    // integers
    runVec("R10 byte minus one", 32'hFF00_0000, 32'hFFFF_FFFF, 0, 3'd0);
    runVec("R10 byte min",       32'h8012_3456, 0, 0, 3'd0);
    runVec("R3 R10 byte zero",   32'h00FF_FFFF, 0, 0, 3'd0);
    runVec("R10 half five",      32'h0005_FFFF, 0, 0, 3'd1);
    runVec("R10 half neg",       32'hFFFE_0000, 0, 0, 3'd1);
    runVec("R10 long min",       32'h8000_0000, 0, 0, 3'd2);
    runVec("R10 long",           32'h1234_5678, 0, 0, 3'd2);
    runVec("R3 long zero",       32'h0000_0000, 0, 0, 3'd2);
    // unsupported codes
    runVec("R2 bad code 6",      32'hFFFF_FFFF, 32'h1, 32'h2, 3'd6);
    runVec("R2 bad code 7",      32'h7F80_0001, 32'h1, 32'h2, 3'd7);
    // random sweep over all codes
    for (int i = 0; i < 400; i++) begin
      rngState = nextRand(rngState); r0 = rngState;
      rngState = nextRand(rngState); r1 = rngState;
      rngState = nextRand(rngState); r2 = rngState;
      if (i % 5 == 0) r0[30:16] = '0;
      if (i % 7 == 0) r0[30:16] = '1;
      runVec("R11 sweep", r0, r1, r2, 3'(i % 8));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule